// File: doc/BRIEF.md
# Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (16 by default) and returns the full product of `2*WIDTH` bits. Partial products come from a recursive vertical-and-crosswise split rather than repeated shift-and-add steps. Each operand is cut into a high and a low half, and four half-width products are formed: low×low, low×high, high×low and high×high. Recursion ends at a 2x2 cell built from AND gates and two half adders. At every level, the two crosswise products are summed, shifted by half a width and added onto the concatenation of the high×high and low×low results. Each of these additions uses a carry-select adder. In every block of that adder, the carry-in-one sum comes from incrementing the carry-in-zero sum.

The multiply path is purely combinational. A single output register captures the product together with a valid flag. A caller presents `a`, `b` and a one-cycle `in_valid` strobe, then reads `prod` on the cycle that `out_valid` is high. Any power of two from 2 upward may be used for `WIDTH`.

Top module: `vc_mul`

## Requirements
- R1: One clock edge after an edge at which `in_valid` is high, `prod` equals the unsigned product of the `a` and `b` sampled at that edge, as a `2*WIDTH`-bit value.
- R2: `out_valid` equals the `in_valid` sampled at the previous clock edge (latency of exactly one cycle).
- R3: When `in_valid` is low at an edge, the `a` and `b` presented are ignored: `prod` keeps its previous value.
- R4: While `rst_n` is low, `out_valid` is 0 and `prod` is 0.
- R5: The largest operands give the largest product: 0xFFFF × 0xFFFF yields 0xFFFE0001, and 0xFFFF × 1 yields 0x0000FFFF, with no bit lost.
- R6: When either accepted operand is zero, the product is zero.
- R7: With `WIDTH` set to 4, every one of the 256 operand pairs gives the exact 8-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `a` and `b` should be multiplied |
| a | input | WIDTH | Multiplicand, unsigned |
| b | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | High in the cycle after an accepted operand pair |
| prod | output | 2*WIDTH | Registered unsigned product |

## Verification
On every cycle, the bound checker compares each accepted pair against the arithmetic product one edge later. It also checks that the valid flag follows the strobe with one cycle of delay, that the product holds while the strobe is low, and that a zero operand gives zero. The reset values and the exhaustive sweep of every 4-bit operand pair come only from the bench's scenarios, which also cover the extreme 16-bit operands and a stream of random pairs. Together these show that the adder boundaries at every level of the recursion carry correctly.

// File: rtl/vc_pkg.sv
package vc_pkg;

    // Block size for the carry-select adders; 4 where it divides the width,
    // else 2 (the only other widths produced by the recursion are 2 and 6).
    function automatic int vc_blk(input int w);
        return (w % 4 == 0) ? 4 : 2;
    endfunction

endpackage

// File: rtl/vc_cell2.sv
module vc_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] p
);
    logic t_lo, t_x, t_y, t_hi, c1;

    always_comb begin
        t_lo = x[0] & y[0];
        t_x  = x[1] & y[0];
        t_y  = x[0] & y[1];
        t_hi = x[1] & y[1];
        // first half adder: the two crosswise terms
        c1   = t_x & t_y;
        p[0] = t_lo;
        p[1] = t_x ^ t_y;
        // second half adder: vertical high term plus crosswise carry
        p[2] = t_hi ^ c1;
        p[3] = t_hi & c1;
    end
endmodule

// File: rtl/vc_csel_add.sv
// Truncating W-bit adder split into blocks; each block forms its carry-0 sum
// and derives the carry-1 sum with an incrementer, then the incoming carry
// selects between them. The last block may be narrower and drops its carry.
module vc_csel_add #(
    parameter int W   = 8,
    parameter int BLK = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    localparam int NB = (W + BLK - 1) / BLK;

    logic [NB-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar g = 0; g < NB; g++) begin : g_blk
        localparam int LO = g * BLK;
        localparam int BW = (W - LO < BLK) ? (W - LO) : BLK;
        if (g < NB - 1) begin : g_mid
            logic [BW:0] s0, s1;
            assign s0 = {1'b0, x[LO +: BW]} + {1'b0, y[LO +: BW]};
            assign s1 = s0 + 1'b1;
            assign s[LO +: BW] = cy[g] ? s1[BW-1:0] : s0[BW-1:0];
            assign cy[g+1]     = cy[g] ? s1[BW]     : s0[BW];
        end else begin : g_last
            logic [BW-1:0] s0, s1;
            assign s0 = x[LO +: BW] + y[LO +: BW];
            assign s1 = s0 + 1'b1;
            assign s[LO +: BW] = cy[g] ? s1 : s0;
        end
    end
endmodule

// File: rtl/vc_unit.sv
// Recursive NxN unsigned multiplier core (N a power of two, N >= 2).
module vc_unit #(
    parameter int N = 16
) (
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    output logic [2*N-1:0] p
);
    import vc_pkg::*;

    if (N == 2) begin : g_base
        vc_cell2 u_cell (.x(x), .y(y), .p(p));
    end else begin : g_rec
        localparam int H  = N / 2;
        localparam int MW = N + 1;      // crosswise sum width
        localparam int UW = N + H;      // upper accumulation width

        logic [N-1:0]  pp_ll, pp_lh, pp_hl, pp_hh;
        logic [MW-1:0] mid;
        logic [UW-1:0] upper;

        vc_unit #(.N(H)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .p(pp_ll));
        vc_unit #(.N(H)) u_lh (.x(x[H-1:0]), .y(y[N-1:H]), .p(pp_lh));
        vc_unit #(.N(H)) u_hl (.x(x[N-1:H]), .y(y[H-1:0]), .p(pp_hl));
        vc_unit #(.N(H)) u_hh (.x(x[N-1:H]), .y(y[N-1:H]), .p(pp_hh));

        // crosswise: LH + HL, one extra bit for its carry
        vc_csel_add #(.W(MW), .BLK(vc_blk(MW - 1))) u_mid (
            .x({1'b0, pp_lh}),
            .y({1'b0, pp_hl}),
            .s(mid)
        );

        // vertical: {HH, LL high half} plus crosswise sum shifted by H
        vc_csel_add #(.W(UW), .BLK(vc_blk(UW))) u_up (
            .x({pp_hh, pp_ll[N-1:H]}),
            .y({{(UW-MW){1'b0}}, mid}),
            .s(upper)
        );

        assign p = {upper, pp_ll[H-1:0]};
    end
endmodule

// File: rtl/vc_mul.sv
module vc_mul #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } out_st_t;

    logic [PW-1:0] raw;
    out_st_t       st_d, st_q;

    vc_unit #(.N(WIDTH)) u_core (.x(a), .y(b), .p(raw));

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prod = raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign prod      = st_q.prod;
endmodule

// File: rtl/vc_mul_chk.sv
module vc_mul_chk #(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   b,
    input logic               out_valid,
    input logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    // R1
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod == (PW'($past(a)) * PW'($past(b))));

    // R2
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod));

    // R6
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a == '0 || b == '0)) |=> prod == '0);
endmodule

bind vc_mul vc_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .prod(prod)
);

// File: tb/vc_mul_tb.sv
module vc_mul_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        out_valid, out_valid4;
    logic [31:0] prod;
    logic [7:0]  prod4;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vc_mul #(.WIDTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(out_valid), .prod(prod)
    );

    vc_mul #(.WIDTH(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a4), .b(b4),
        .out_valid(out_valid4), .prod(prod4)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
        end
    endtask

    // drive at a falling edge, check one falling edge later
    task automatic mul16(input string req, input logic [15:0] x, input logic [15:0] y);
        logic [31:0] exp;
        exp = 32'(x) * 32'(y);
        @(negedge clk);
        a = x; b = y; in_valid = 1'b1;
        @(negedge clk);
        check(req, 64'(prod), 64'(exp));
        check("R2", 64'(out_valid), 64'd1);
    endtask

    initial begin
        logic [31:0] held;
        logic [7:0]  held4;
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4", 64'(out_valid), 64'd0);
        check("R4", 64'(prod), 64'd0);
        check("R4", 64'(out_valid4), 64'd0);
        rst_n = 1'b1;

        // R5 / R6 corners
        mul16("R5", 16'hFFFF, 16'hFFFF);
        check("R5", 64'(prod), 64'hFFFE0001);
        mul16("R5", 16'hFFFF, 16'h0001);
        mul16("R6", 16'h0000, 16'hFFFF);
        mul16("R6", 16'hBEEF, 16'h0000);
        mul16("R1", 16'h0001, 16'h0001);
        mul16("R1", 16'h8000, 16'h8000);
        mul16("R1", 16'h00FF, 16'hFF00);
        mul16("R1", 16'hAAAA, 16'h5555);

        // R3: inputs ignored while strobe is low
        held = prod;
        @(negedge clk);
        in_valid = 1'b0; a = 16'h1234; b = 16'h4321;
        @(negedge clk);
        check("R3", 64'(prod), 64'(held));
        check("R2", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R3", 64'(prod), 64'(held));

        // R7: exhaustive 4-bit sweep, with a random 16-bit stream alongside
        for (int i = 0; i < 256; i++) begin
            logic [15:0] rx, ry;
            rx = 16'($urandom); ry = 16'($urandom);
            @(negedge clk);
            a4 = 4'(i >> 4); b4 = 4'(i); a = rx; b = ry; in_valid = 1'b1;
            @(negedge clk);
            check("R7", 64'(prod4), 64'(8'(i >> 4) * 8'(i & 15)));
            check("R1", 64'(prod), 64'(32'(rx) * 32'(ry)));
        end

        // R3 on the small configuration
        held4 = prod4;
        @(negedge clk);
        in_valid = 1'b0; a4 = 4'hF; b4 = 4'hF;
        @(negedge clk);
        check("R3", 64'(prod4), 64'(held4));
        check("R2", 64'(out_valid4), 64'd0);

        // more random 16-bit pairs
        for (int k = 0; k < 500; k++) begin
            mul16("R1", 16'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule